// File: doc/BRIEF.md
# Fixed-Interval Timer Interrupt Unit

This unit watches a free-running 64-bit time base. It raises a noncritical interrupt each time a chosen bit of that count goes from 0 to 1. Software picks one of four tap positions through a small control word and gates the interrupt with an enable bit in the same word. A sticky status flag records every time-out. A request line follows that flag one cycle later.

The interrupt is taken only when the request, the control enable and the external-interrupt enable of the machine-state register are all set. When it is taken, the unit does four things in the same clock:
- It stores the next sequential instruction address in save/restore register 0.
- It stores the whole machine-state register in save/restore register 1.
- It clears every machine-state bit except the critical, machine-check and debug enables.
- It presents the vector offset 0x1010.

Software acknowledges the time-out by writing a 1 to the status clear port. A return pulse copies save/restore register 1 back into the machine-state register. If the status was left set, the interrupt is taken again.

Top module: `fit_intr_unit`

## Requirements
- R1: The status flag `fitStatus` sets on the clock edge at which the selected tap of `timeBase` is 1 and was 0 on the previous edge. The tap is bit 9 + 4·sel, where sel is `ctlWdata[1:0]` (sel 0..3 gives bits 9, 13, 17 and 21), and `ctlWdata[2]` is the interrupt enable. A tap that merely stays high does not set the flag.
- R2: Rising edges on bits other than the selected tap leave the flag untouched. Selecting a tap that is already high does not set the flag, because each tap keeps its own edge history.
- R3: `fitReq` equals the value `fitStatus` had one clock earlier.
- R4: The flag stays set until a write with `stsWe`=1 and `stsWdata`=1 clears it. A write with `stsWdata`=0 has no effect. A time-out in the same cycle as a clear leaves the flag set.
- R5: The interrupt is taken (`intTaken`=1) only when `fitReq`, the control enable and machine-state bit 3 (external-interrupt enable) are all 1. The status flag sets whatever the enables are. Because taking the interrupt clears bit 3, one entry produces exactly one take.
- R6: On a take, `srr0Q` captures `nextPc` and `srr1Q` captures `msrQ` as it was before the edge. During the take cycle `vecOffset` is 0x1010, and 0 in all other cycles.
- R7: On a take, the 14-bit `msrQ` keeps bits 0 (critical enable), 1 (machine-check enable) and 2 (debug enable) and clears bits 3 to 13.
- R8: A pulse on `intRet` copies `srr1Q` into `msrQ` and leaves both save/restore registers unchanged. A status flag still set then causes a new take.
- R9: When several machine-state updates meet in one cycle, a take beats `intRet`, and `intRet` beats a software write (`msrWe`).
- R10: After reset, status, request, control word, machine-state and both save/restore registers read 0 and `vecOffset` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| timeBase | input | 64 | Free-running time-base count |
| nextPc | input | 32 | Address of the next sequential instruction |
| ctlWe | input | 1 | Control word write strobe |
| ctlWdata | input | 3 | Control word: [2] enable, [1:0] tap select |
| stsWe | input | 1 | Status write strobe |
| stsWdata | input | 1 | Status write data; 1 clears the flag |
| msrWe | input | 1 | Machine-state software write strobe |
| msrWdata | input | 14 | Machine-state write data |
| intRet | input | 1 | Interrupt-return pulse |
| ctlQ | output | 3 | Current control word |
| fitStatus | output | 1 | Sticky time-out flag |
| fitReq | output | 1 | Interrupt request |
| intTaken | output | 1 | High in the cycle the interrupt is taken |
| vecOffset | output | 16 | Vector offset, valid with intTaken |
| msrQ | output | 14 | Machine-state register |
| srr0Q | output | 32 | Saved return address |
| srr1Q | output | 14 | Saved machine state |

## Verification
The bench drives a time base with bits held high for several cycles. A detector that looks at levels instead of edges would then set the flag again and again. It also switches the tap select onto a bit that is already high, where a design with a single shared history flop would report a false time-out. A clear and a time-out are made to land on the same edge, so a design that lets the clear win loses the event. The bench also holds the request while only one of the two enables is set, and it stacks a take, a return and a software write into one cycle. A wrong enable gate, a wrong priority or a wrong keep mask then shows up directly in `msrQ` and `intTaken`.

// File: rtl/fit_pkg.sv
package fit_pkg;
  localparam int TB_W     = 64;
  localparam int ADDR_W   = 32;
  localparam int MSR_W    = 14;
  localparam int SEL_W    = 2;
  localparam int TAP_LSB  = 9;
  localparam int TAP_STEP = 4;
  localparam int CTL_W    = SEL_W + 1;
  localparam int VEC_W    = 16;
  localparam logic [VEC_W-1:0] VEC_OFF = 16'h1010;

  // machine-state bit positions
  localparam int MSR_CRIT = 0;
  localparam int MSR_MCHK = 1;
  localparam int MSR_DBG  = 2;
  localparam int MSR_EXT  = 3;

  localparam logic [MSR_W-1:0] MSR_KEEP =
    (MSR_W'(1) << MSR_CRIT) | (MSR_W'(1) << MSR_MCHK) | (MSR_W'(1) << MSR_DBG);

  typedef struct packed {
    logic take;
    logic ret;
    logic msrWr;
  } strobe_t;
endpackage

// File: rtl/fit_ctrl.sv
module fit_ctrl
  import fit_pkg::*;
#(
  parameter int TBW  = TB_W,
  parameter int SELW = SEL_W,
  parameter int LSB  = TAP_LSB,
  parameter int STEP = TAP_STEP
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [TBW-1:0]  timeBase,
  input  logic            ctlWe,
  input  logic [SELW:0]   ctlWdata,
  input  logic            stsWe,
  input  logic            stsWdata,
  input  logic            msrWe,
  input  logic            intRet,
  input  logic            msrExtEn,
  output logic            fitEnable,
  output logic [SELW-1:0] intervalSel,
  output logic            fitStatus,
  output logic            fitReq,
  output strobe_t         strobes
);
  localparam int NUM_TAPS = 1 << SELW;

  logic [NUM_TAPS-1:0] tapNow;
  logic [NUM_TAPS-1:0] tapPrev;
  logic [NUM_TAPS-1:0] tapRise;
  logic                timeout;
  logic                stsClr;
  logic                take;
  logic                unusedTimeBase;

  // pick the candidate tap bits out of the time base
  for (genvar i = 0; i < NUM_TAPS; i++) begin : g_tap
    assign tapNow[i] = timeBase[LSB + i * STEP];
  end

  assign unusedTimeBase = ^timeBase;

  // every tap keeps its own history, so a change of select cannot fake an edge
  assign tapRise = tapNow & ~tapPrev;
  assign timeout = tapRise[intervalSel];
  assign stsClr  = stsWe & stsWdata;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tapPrev     <= '0;
      fitEnable   <= 1'b0;
      intervalSel <= '0;
      fitStatus   <= 1'b0;
      fitReq      <= 1'b0;
    end else begin
      tapPrev <= tapNow;
      if (ctlWe) begin
        fitEnable   <= ctlWdata[SELW];
        intervalSel <= ctlWdata[SELW-1:0];
      end
      if (timeout)     fitStatus <= 1'b1;   // a new time-out beats a clear
      else if (stsClr) fitStatus <= 1'b0;
      fitReq <= fitStatus;
    end
  end

  assign take = fitReq & fitEnable & msrExtEn;

  always_comb begin
    strobes.take  = take;
    strobes.ret   = intRet & ~take;
    strobes.msrWr = msrWe & ~take & ~intRet;
  end

  p_rise_sets_r1: assert property (@(posedge clk) disable iff (!rstN)
    timeout |=> fitStatus);

  p_req_lag_r3: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (fitReq == $past(fitStatus)));

  p_sticky_r4: assert property (@(posedge clk) disable iff (!rstN)
    (fitStatus && !stsClr) |=> fitStatus);

  p_clear_r4: assert property (@(posedge clk) disable iff (!rstN)
    (stsClr && !timeout) |=> !fitStatus);
endmodule

// File: rtl/fit_dpath.sv
module fit_dpath
  import fit_pkg::*;
#(
  parameter int AW   = ADDR_W,
  parameter int MW   = MSR_W,
  parameter int VW   = VEC_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  strobe_t       strobes,
  input  logic [AW-1:0] nextPc,
  input  logic [MW-1:0] msrWdata,
  output logic [MW-1:0] msrQ,
  output logic [AW-1:0] srr0Q,
  output logic [MW-1:0] srr1Q,
  output logic          msrExtEn,
  output logic          intTaken,
  output logic [VW-1:0] vecOffset
);
  logic [MW-1:0] msrNext;

  // priority: take, then return, then software write
  always_comb begin
    msrNext = msrQ;
    if (strobes.take)       msrNext = msrQ & MSR_KEEP;
    else if (strobes.ret)   msrNext = srr1Q;
    else if (strobes.msrWr) msrNext = msrWdata;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      msrQ  <= '0;
      srr0Q <= '0;
      srr1Q <= '0;
    end else begin
      msrQ <= msrNext;
      if (strobes.take) begin
        srr0Q <= nextPc;
        srr1Q <= msrQ;
      end
    end
  end

  assign msrExtEn  = msrQ[MSR_EXT];
  assign intTaken  = strobes.take;
  assign vecOffset = strobes.take ? VEC_OFF : '0;

  p_take_once_r5: assert property (@(posedge clk) disable iff (!rstN)
    intTaken |=> !intTaken);

  p_save_r6: assert property (@(posedge clk) disable iff (!rstN)
    strobes.take |=> (srr1Q == $past(msrQ)) && (srr0Q == $past(nextPc)));

  p_mask_r7: assert property (@(posedge clk) disable iff (!rstN)
    strobes.take |=> (msrQ == ($past(msrQ) & MSR_KEEP)));

  p_restore_r8: assert property (@(posedge clk) disable iff (!rstN)
    strobes.ret |=> (msrQ == $past(srr1Q)) && $stable(srr1Q));
endmodule

// File: rtl/fit_intr_unit.sv
module fit_intr_unit
  import fit_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [TB_W-1:0]   timeBase,
  input  logic [ADDR_W-1:0] nextPc,
  input  logic              ctlWe,
  input  logic [CTL_W-1:0]  ctlWdata,
  input  logic              stsWe,
  input  logic              stsWdata,
  input  logic              msrWe,
  input  logic [MSR_W-1:0]  msrWdata,
  input  logic              intRet,
  output logic [CTL_W-1:0]  ctlQ,
  output logic              fitStatus,
  output logic              fitReq,
  output logic              intTaken,
  output logic [VEC_W-1:0]  vecOffset,
  output logic [MSR_W-1:0]  msrQ,
  output logic [ADDR_W-1:0] srr0Q,
  output logic [MSR_W-1:0]  srr1Q
);
  strobe_t          strobes;
  logic             msrExtEn;
  logic             fitEnable;
  logic [SEL_W-1:0] intervalSel;

  fit_ctrl #(
    .TBW (TB_W),
    .SELW(SEL_W),
    .LSB (TAP_LSB),
    .STEP(TAP_STEP)
  ) ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .timeBase   (timeBase),
    .ctlWe      (ctlWe),
    .ctlWdata   (ctlWdata),
    .stsWe      (stsWe),
    .stsWdata   (stsWdata),
    .msrWe      (msrWe),
    .intRet     (intRet),
    .msrExtEn   (msrExtEn),
    .fitEnable  (fitEnable),
    .intervalSel(intervalSel),
    .fitStatus  (fitStatus),
    .fitReq     (fitReq),
    .strobes    (strobes)
  );

  fit_dpath #(
    .AW(ADDR_W),
    .MW(MSR_W),
    .VW(VEC_W)
  ) dpath_i (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .nextPc   (nextPc),
    .msrWdata (msrWdata),
    .msrQ     (msrQ),
    .srr0Q    (srr0Q),
    .srr1Q    (srr1Q),
    .msrExtEn (msrExtEn),
    .intTaken (intTaken),
    .vecOffset(vecOffset)
  );

  assign ctlQ = {fitEnable, intervalSel};
endmodule

// File: tb/fit_intr_unit_tb_top.sv
`timescale 1ns/1ps
module fit_intr_unit_tb_top;
  logic        clk = 1'b0;
  logic        rstN;
  logic [63:0] timeBase;
  logic [31:0] nextPc;
  logic        ctlWe;
  logic [2:0]  ctlWdata;
  logic        stsWe;
  logic        stsWdata;
  logic        msrWe;
  logic [13:0] msrWdata;
  logic        intRet;
  logic [2:0]  ctlQ;
  logic        fitStatus;
  logic        fitReq;
  logic        intTaken;
  logic [15:0] vecOffset;
  logic [13:0] msrQ;
  logic [31:0] srr0Q;
  logic [13:0] srr1Q;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  fit_intr_unit dut_i (
    .clk(clk), .rstN(rstN), .timeBase(timeBase), .nextPc(nextPc),
    .ctlWe(ctlWe), .ctlWdata(ctlWdata), .stsWe(stsWe), .stsWdata(stsWdata),
    .msrWe(msrWe), .msrWdata(msrWdata), .intRet(intRet),
    .ctlQ(ctlQ), .fitStatus(fitStatus), .fitReq(fitReq), .intTaken(intTaken),
    .vecOffset(vecOffset), .msrQ(msrQ), .srr0Q(srr0Q), .srr1Q(srr1Q)
  );

  // entry: [15:14] select, [13:8] bit driven high, [0] flag expected
  localparam logic [15:0] TAP_VECS [8] = '{
    16'h0901, 16'h4D01, 16'h9101, 16'hD501,
    16'h0D00, 16'h4900, 16'hD400, 16'hBF00
  };

  task automatic check(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic step(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog (all requirements): actual=timeout expected=completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rstN = 1'b0; timeBase = '0; nextPc = '0; ctlWe = 0; ctlWdata = '0;
    stsWe = 0; stsWdata = 0; msrWe = 0; msrWdata = '0; intRet = 0;
    step(3);
    rstN = 1'b1;
    step();
    // R10 reset state
    check("R10", "status", fitStatus, 0);
    check("R10", "req", fitReq, 0);
    check("R10", "ctl", ctlQ, 0);
    check("R10", "msr", msrQ, 0);
    check("R10", "srr0", srr0Q, 0);
    check("R10", "srr1", srr1Q, 0);
    check("R10", "vector", vecOffset, 0);

    // R1 / R2 tap table
    for (int k = 0; k < 8; k++) begin
      timeBase = '0; ctlWe = 1; ctlWdata = {1'b0, TAP_VECS[k][15:14]};
      stsWe = 1; stsWdata = 1;
      step();
      ctlWe = 0; stsWe = 0;
      timeBase = 64'd1 << TAP_VECS[k][13:8];
      step();
      check(TAP_VECS[k][0] ? "R1" : "R2", "tap edge", fitStatus, TAP_VECS[k][0]);
    end

    // R1 steady high bit does not retrigger
    timeBase = '0; ctlWe = 1; ctlWdata = 3'b000; step();
    ctlWe = 0; timeBase = 64'd1 << 9; step();
    stsWe = 1; stsWdata = 1; step();
    stsWe = 0; step(2);
    check("R1", "steady high", fitStatus, 0);

    // R2 reselect onto a tap already high
    timeBase = (64'd1 << 9) | (64'd1 << 13); step(2);
    ctlWe = 1; ctlWdata = 3'b001; step();
    ctlWe = 0; step(2);
    check("R2", "reselect high tap", fitStatus, 0);

    // R3 request lags status by one cycle
    timeBase = '0; step();
    timeBase = 64'd1 << 13; step();
    check("R3", "status set", fitStatus, 1);
    check("R3", "req not yet", fitReq, 0);
    step();
    check("R3", "req follows", fitReq, 1);

    // R4 sticky, write-0 ignored, set beats clear
    stsWe = 1; stsWdata = 0; step();
    stsWe = 0;
    check("R4", "write zero ignored", fitStatus, 1);
    timeBase = '0; step();
    timeBase = 64'd1 << 13; stsWe = 1; stsWdata = 1; step();
    check("R4", "set beats clear", fitStatus, 1);
    step();
    check("R4", "clear", fitStatus, 0);
    stsWe = 0; step();
    check("R4", "req drops", fitReq, 0);

    // R5 both enables required, status sets regardless
    msrWe = 1; msrWdata = 14'h0008; ctlWe = 1; ctlWdata = 3'b001; step();
    msrWe = 0; ctlWe = 0; timeBase = '0; step();
    timeBase = 64'd1 << 13; step();
    check("R5", "status while disabled", fitStatus, 1);
    step();
    check("R5", "no take without ctl enable", intTaken, 0);
    msrWe = 1; msrWdata = 14'h0000; ctlWe = 1; ctlWdata = 3'b101; step();
    msrWe = 0; ctlWe = 0;
    check("R5", "no take without msr enable", intTaken, 0);
    step();
    check("R5", "still no take", intTaken, 0);

    // R6 / R7 take
    nextPc = 32'h1234_5678; msrWe = 1; msrWdata = 14'h3FFF; step();
    msrWe = 0;
    check("R6", "take", intTaken, 1);
    check("R6", "vector", vecOffset, 16'h1010);
    step();
    check("R6", "srr0", srr0Q, 32'h1234_5678);
    check("R6", "srr1", srr1Q, 14'h3FFF);
    check("R7", "msr masked", msrQ, 14'h0007);
    check("R5", "single take", intTaken, 0);
    check("R6", "vector idle", vecOffset, 0);

    // R8 return restores, persistent status retakes
    intRet = 1; step();
    intRet = 0;
    check("R8", "msr restored", msrQ, 14'h3FFF);
    check("R8", "srr0 kept", srr0Q, 32'h1234_5678);
    check("R8", "retake", intTaken, 1);
    nextPc = 32'hCAFE_0000; step();
    check("R8", "srr0 new", srr0Q, 32'hCAFE_0000);
    check("R7", "msr masked again", msrQ, 14'h0007);

    // R9 priority
    intRet = 1; step();
    check("R9", "take pending", intTaken, 1);
    msrWe = 1; msrWdata = 14'h0AAA; step();
    check("R9", "take beats ret/write", msrQ, 14'h0007);
    intRet = 0; msrWe = 0; stsWe = 1; stsWdata = 1; step(2);
    stsWe = 0;
    intRet = 1; msrWe = 1; msrWdata = 14'h0000; step();
    intRet = 0; msrWe = 0;
    check("R9", "ret beats write", msrQ, 14'h3FFF);
    check("R9", "no take", intTaken, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule